// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block turns a 32-bit request address into a bank selection for a four-bank SDRAM controller. The register file supplies one 32-bit configuration word per bank and a controller-wide enable. Each word gives the bank's start address, its size and a valid bit. The decoder checks the address against every bank in parallel. It reports whether some live bank contains the address, which bank that is, and how far into the bank the address lies.

A bank's start address is the top nine bits of its word, so banks start on 8 MiB boundaries. Its size is 4 MiB shifted left by a 3-bit code, which gives 4 MiB up to 256 MiB. The top code value is not a legal size, and a bank that carries it never decodes. If banks are configured to overlap, the lowest-numbered bank that contains the address is selected and a separate overlap flag is raised. All results are registered, so they appear on the clock edge that follows the address.

Top module: `sdram_bank_decoder`

## Requirements
- R1: A synchronous active-high reset clears the hit, bank index, offset and overlap outputs to zero.
- R2: Bits 31:23 of a bank's configuration word, followed by 23 zero bits, form the bank start address. The bank covers addresses from that start up to, but not including, start plus size.
- R3: Bits 19:17 of a bank's configuration word hold the size code. Codes 0 to 6 select a size of 4 MiB shifted left by the code. An address exactly at start plus size does not hit.
- R4: A bank whose size code is 7 never produces a hit.
- R5: A bank decodes only when bit 0 of its configuration word is 1.
- R6: When the global enable is 0, no bank produces a hit.
- R7: On a hit, the offset output is the address minus the bank start address, 28 bits wide. All outputs reflect the address and configuration present at the previous rising clock edge.
- R8: When two or more live banks contain the address, the bank index output is the lowest-numbered of them.
- R9: The overlap output is 1 exactly when two or more live banks contain the address. Overlap never appears without a hit.
- R10: On a miss, the bank index and offset outputs are zero.
- R11: Bits 22:20 and 16:1 of a configuration word have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller-wide decode enable |
| bank_cfg_i | input | 128 | Four 32-bit bank configuration words; bank 0 in bits 31:0 |
| addr_i | input | 32 | Request address |
| hit_o | output | 1 | Address lies in a live bank (registered) |
| bank_o | output | 2 | Index of the selected bank (registered) |
| offset_o | output | 28 | Address offset within the selected bank (registered) |
| overlap_o | output | 1 | More than one live bank contains the address (registered) |

## Verification
The block keeps no state except its output register. A wrong field extraction or a wrong range compare therefore shows up on the very next edge, as a wrong hit, a wrong bank index or a wrong offset for a single address. The stimulus places addresses on both sides of every bank boundary, because an off-by-one in the size shift or the start compare shows up only there. Overlapping banks and an illegal size code are also exercised, because a priority error or a wrongly accepted code shows up only on the overlap flag or in the choice of bank.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

    parameter int NUM_BANKS   = 4;
    parameter int ADDR_W      = 32;
    parameter int WORD_W      = 32;
    parameter int BASE_LSB    = 23;   // start address granule: 8 MiB
    parameter int MIN_SZ_LSB  = 22;   // smallest bank: 4 MiB
    parameter int CODE_LSB    = 17;
    parameter int CODE_W      = 3;
    parameter int MAX_CODE    = 6;    // largest legal size code
    parameter int OFS_W       = 28;   // covers the largest bank

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int BASE_W = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic              live;
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } bank_map_t;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
        logic              overlap;
    } dec_result_t;

    function automatic logic size_code_ok(input logic [CODE_W-1:0] code);
        return int'(code) <= MAX_CODE;
    endfunction

    function automatic logic [ADDR_W-1:0] bank_span(input logic [CODE_W-1:0] code);
        logic [ADDR_W-1:0] one_unit;
        one_unit = ADDR_W'(1) << MIN_SZ_LSB;
        return one_unit << code;
    endfunction

endpackage

// File: rtl/bank_field_extract.sv
module bank_field_extract
    import sdram_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              enable_i,
    output bank_map_t         map_o
);
    logic [CODE_W-1:0] code;
    logic              unused_bits;

    assign code        = word_i[CODE_LSB +: CODE_W];
    // Reserved fields take no part in decoding.
    assign unused_bits = ^{word_i[BASE_LSB-1:CODE_LSB+CODE_W], word_i[CODE_LSB-1:1]};

    always_comb begin
        map_o.base = word_i[WORD_W-1:BASE_LSB];
        map_o.code = code;
        map_o.live = word_i[0] & enable_i & size_code_ok(code);
    end
endmodule

// File: rtl/bank_range_match.sv
module bank_range_match
    import sdram_dec_pkg::*;
(
    input  bank_map_t         map_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              match_o,
    output logic [OFS_W-1:0]  ofs_o
);
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] delta;
    logic              above_start;
    logic              below_end;
    logic              unused_delta;

    always_comb begin
        start_addr  = {map_i.base, {BASE_LSB{1'b0}}};
        span        = bank_span(map_i.code);
        delta       = addr_i - start_addr;
        above_start = addr_i >= start_addr;
        below_end   = delta < span;
        match_o     = map_i.live & above_start & below_end;
        ofs_o       = match_o ? delta[OFS_W-1:0] : '0;
    end

    assign unused_delta = ^delta[ADDR_W-1:OFS_W];
endmodule

// File: rtl/bank_priority_select.sv
module bank_priority_select
    import sdram_dec_pkg::*;
(
    input  logic [NUM_BANKS-1:0]            match_i,
    input  logic [NUM_BANKS-1:0][OFS_W-1:0] ofs_i,
    output dec_result_t                     res_o
);
    logic [BANK_W:0] n_match;

    always_comb begin
        res_o   = '0;
        n_match = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                res_o.hit  = 1'b1;
                res_o.bank = BANK_W'(i);
                res_o.ofs  = ofs_i[i];
            end
        end
        for (int i = 0; i < NUM_BANKS; i++) begin
            n_match = n_match + (BANK_W + 1)'(match_i[i]);
        end
        res_o.overlap = n_match > 1;
    end
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
    import sdram_dec_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable_i,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_cfg_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic                        hit_o,
    output logic [BANK_W-1:0]           bank_o,
    output logic [OFS_W-1:0]            offset_o,
    output logic                        overlap_o
);
    bank_map_t                      maps     [NUM_BANKS];
    logic [NUM_BANKS-1:0]           live_vec;
    logic [NUM_BANKS-1:0]           match_vec;
    logic [NUM_BANKS-1:0][OFS_W-1:0] ofs_vec;
    dec_result_t                    res_next;
    dec_result_t                    res_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_field_extract u_fields (
            .word_i   (bank_cfg_i[b*WORD_W +: WORD_W]),
            .enable_i (enable_i),
            .map_o    (maps[b])
        );
        bank_range_match u_match (
            .map_i   (maps[b]),
            .addr_i  (addr_i),
            .match_o (match_vec[b]),
            .ofs_o   (ofs_vec[b])
        );
        assign live_vec[b] = maps[b].live;

        // R4, R5: a bank that was not live last cycle is never reported now.
        p_dead_bank_silent_r4: assert property (@(posedge clk) disable iff (rst)
            (hit_o && bank_o == BANK_W'(b)) |-> $past(live_vec[b]));
    end

    bank_priority_select u_sel (
        .match_i (match_vec),
        .ofs_i   (ofs_vec),
        .res_o   (res_next)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_next;
    end

    assign hit_o     = res_q.hit;
    assign bank_o    = res_q.bank;
    assign offset_o  = res_q.ofs;
    assign overlap_o = res_q.overlap;

    logic [NUM_BANKS-1:0] lower_mask;
    assign lower_mask = (NUM_BANKS'(1) << bank_o) - NUM_BANKS'(1);

    p_enable_off_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> !hit_o);

    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (($past(match_vec) & lower_mask) == '0));

    p_overlap_has_hit_r9: assert property (@(posedge clk) disable iff (rst)
        overlap_o |-> hit_o);

    p_miss_clean_r10: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (bank_o == '0 && offset_o == '0));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!hit_o && !overlap_o));
endmodule

// File: tb/tb_sdram_bank_decoder.sv
module tb_sdram_bank_decoder;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable_i = 1'b0;
    logic [127:0] bank_cfg_i = '0;
    logic [31:0]  addr_i = '0;
    logic         hit_o;
    logic [1:0]   bank_o;
    logic [27:0]  offset_o;
    logic         overlap_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_bank_decoder dut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .bank_cfg_i(bank_cfg_i),
        .addr_i(addr_i), .hit_o(hit_o), .bank_o(bank_o),
        .offset_o(offset_o), .overlap_o(overlap_o)
    );

    typedef struct packed {
        logic [127:0] cfg;   // {bank3, bank2, bank1, bank0}
        logic         en;
        logic [31:0]  addr;
        logic         hit;
        logic [1:0]   bank;
        logic [27:0]  ofs;
        logic         ovl;
    } vec_t;

    // Config A: b0 0x0000_0000/32M, b1 0x0200_0000/16M, b2 0x1000_0000/256M, b3 0xFF80_0000/4M
    localparam logic [127:0] CFG_A = {32'hFF80_0001, 32'h100C_0001, 32'h0204_0001, 32'h0006_0001};
    // Config B: b0 0x0200_0000/4M, b1 0/256M, b2 code 7, b3 valid clear
    localparam logic [127:0] CFG_B = {32'h0002_0000, 32'h000E_0001, 32'h000C_0001, 32'h0200_0001};
    // Config C: B with bank 0 valid clear
    localparam logic [127:0] CFG_C = {32'h0002_0000, 32'h000E_0001, 32'h000C_0001, 32'h0200_0000};
    // Config E: A with reserved bits of bank 0 all set
    localparam logic [127:0] CFG_E = {32'hFF80_0001, 32'h100C_0001, 32'h0204_0001, 32'h0077_FFFF};
    // Config F: only bank 0, code 7
    localparam logic [127:0] CFG_F = {32'h0, 32'h0, 32'h0, 32'h000E_0001};

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{CFG_A, 1'b1, 32'h0000_1234, 1'b1, 2'd0, 28'h000_1234, 1'b0},  // R2 R7
        '{CFG_A, 1'b1, 32'h01FF_FFFF, 1'b1, 2'd0, 28'h1FF_FFFF, 1'b0},  // R3 last byte
        '{CFG_A, 1'b1, 32'h0200_0000, 1'b1, 2'd1, 28'h000_0000, 1'b0},  // R3 end is exclusive
        '{CFG_A, 1'b1, 32'h02FF_FFFF, 1'b1, 2'd1, 28'h0FF_FFFF, 1'b0},  // R3
        '{CFG_A, 1'b1, 32'h0300_0000, 1'b0, 2'd0, 28'h000_0000, 1'b0},  // R10 gap
        '{CFG_A, 1'b1, 32'h1FFF_FFF0, 1'b1, 2'd2, 28'hFFF_FFF0, 1'b0},  // R3 256M
        '{CFG_A, 1'b1, 32'h2000_0000, 1'b0, 2'd0, 28'h000_0000, 1'b0},  // R10
        '{CFG_A, 1'b1, 32'hFFBF_FFFF, 1'b1, 2'd3, 28'h03F_FFFF, 1'b0},  // R2 top base
        '{CFG_A, 1'b1, 32'hFFC0_0000, 1'b0, 2'd0, 28'h000_0000, 1'b0},  // R3 4M end
        '{CFG_A, 1'b1, 32'hFF7F_FFFF, 1'b0, 2'd0, 28'h000_0000, 1'b0},  // R2 below start
        '{CFG_B, 1'b1, 32'h0210_0000, 1'b1, 2'd0, 28'h010_0000, 1'b1},  // R8 R9
        '{CFG_B, 1'b1, 32'h0000_0010, 1'b1, 2'd1, 28'h000_0010, 1'b0},  // R4 R5 R9
        '{CFG_C, 1'b1, 32'h0210_0000, 1'b1, 2'd1, 28'h210_0000, 1'b0},  // R5
        '{CFG_A, 1'b0, 32'h0000_1234, 1'b0, 2'd0, 28'h000_0000, 1'b0},  // R6
        '{CFG_E, 1'b1, 32'h01FF_FFFF, 1'b1, 2'd0, 28'h1FF_FFFF, 1'b0},  // R11
        '{CFG_E, 1'b1, 32'h0200_0000, 1'b1, 2'd1, 28'h000_0000, 1'b0},  // R11
        '{CFG_F, 1'b1, 32'h0000_0010, 1'b0, 2'd0, 28'h000_0000, 1'b0}   // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input vec_t v);
        check({req, " hit"},     32'(hit_o),     32'(v.hit));
        check({req, " bank"},    32'(bank_o),    32'(v.bank));
        check({req, " offset"},  32'(offset_o),  32'(v.ofs));
        check({req, " overlap"}, 32'(overlap_o), 32'(v.ovl));
    endtask

    initial begin
        // R1: reset held while a hitting address is present
        enable_i   = 1'b1;
        bank_cfg_i = CFG_A;
        addr_i     = 32'h0000_1234;
        repeat (3) @(negedge clk);
        check_outputs("R1 reset", '{CFG_A, 1'b1, 32'h0, 1'b0, 2'd0, 28'h0, 1'b0});
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bank_cfg_i = VECS[i].cfg;
            enable_i   = VECS[i].en;
            addr_i     = VECS[i].addr;
            @(negedge clk);
            check_outputs($sformatf("R7 vector %0d", i), VECS[i]);
        end

        // R1: reset in mid-run clears a live overlap result
        @(negedge clk);
        bank_cfg_i = CFG_B; enable_i = 1'b1; addr_i = 32'h0210_0000;
        @(negedge clk);
        check("R9 pre-reset overlap", 32'(overlap_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check_outputs("R1 mid-run reset", '{CFG_B, 1'b1, 32'h0, 1'b0, 2'd0, 28'h0, 1'b0});
        rst = 1'b0;

        // R7: back-to-back addresses, one per cycle
        addr_i = 32'h0000_0020;
        @(negedge clk);
        addr_i = 32'h0200_0004;
        check("R7 pipelined offset a", 32'(offset_o), 32'h20);
        @(negedge clk);
        check("R7 pipelined offset b", 32'(offset_o), 32'h4);
        check("R8 pipelined bank b", 32'(bank_o), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule